// File: doc/BRIEF.md
# Double-Rate Multi-Line Flash Read Responder

This block is the device-side logic of a serial flash that answers two fast read instructions. Both instructions move the address and the data on both serial-clock edges. One uses two data lines and the other uses four. The host selects the device by pulling chip select low and shifts an 8-bit instruction on line 0, one bit per rising edge. The responder then gathers a 24-bit start address on both edges and counts a fixed number of dummy clocks. After that it streams bytes from a byte-addressed array on both edges until chip select rises. The array is reached through a synchronous read port with a one-cycle latency. The address advances after every byte and wraps from the top of the array to zero.

The block does not run on the serial clock. It samples chip select, the serial clock and the data lines with its own system clock and detects the serial-clock edges from those samples. Each serial half-period must last at least four system-clock cycles.

An external program/erase controller supplies a busy flag, and a status register supplies a quad-enable bit. A read that arrives while busy is set is ignored. A four-line read is also ignored while quad-enable is clear. The four-line read carries an 8-bit mode field. When the two nibbles of that field are bitwise complements, the next chip-select cycle skips the instruction and starts straight at the address phase.

Top module: `dtr_flash_rd`

## Requirements
- R1: The instruction is 8 bits, MSB first, on sio_in[0], captured on rising serial-clock edges. 0xBD selects the two-line read and 0xED selects the four-line read. Any other value leaves sio_oe at 0 until chip select rises.
- R2: The two-line read takes the 24-bit address MSB first, 2 bits per edge with sio_in[1] as the more significant bit, on every edge starting with a rising one. Six dummy clocks follow.
- R3: The four-line read takes the address 4 bits per edge on sio_in[3:0], MSB first. An 8-bit mode field follows in one clock, high nibble on the rising edge and low nibble on the falling edge. Seven dummy clocks follow.
- R4: The first data slot appears after the falling edge that ends the dummy phase, and every later edge advances one slot. Each byte goes out MSB first, 2 bits per slot on sio_out[1:0] (bit 1 more significant) for the two-line read, or 4 bits per slot on sio_out[3:0] for the four-line read.
- R5: The byte address rises by one per byte. It wraps from the top array location (2^ARRAY_AW - 1) to 0. Address bits above ARRAY_AW are ignored.
- R6: A four-line read issued while quad_en is 0 is ignored for the rest of that chip-select cycle.
- R7: While busy is 1, both read instructions are ignored for the rest of that chip-select cycle.
- R8: A mode field whose high nibble is the bitwise complement of its low nibble makes the next chip-select cycle begin directly with a four-line address. Any other mode field makes the next cycle expect an instruction.
- R9: Chip select high ends any read at once. sio_oe returns to 0, and no further array reads are issued.
- R10: sio_oe is 0 outside the data phase. In the data phase it is 4'b0011 for the two-line read and 4'b1111 for the four-line read.
- R11: During and after reset, sio_oe and mem_rd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sio_in | input | 4 | Serial data lines as seen from the pins |
| sio_out | output | 4 | Serial data driven during the data phase |
| sio_oe | output | 4 | Per-line output enable |
| quad_en | input | 1 | Quad-enable status bit |
| busy | input | 1 | Program/erase/status-write in progress |
| mem_rd | output | 1 | Array read strobe |
| mem_addr | output | ARRAY_AW | Array read address |
| mem_rdata | input | 8 | Array read data, valid one cycle after mem_rd |

## Verification
The bench starts reads at the last array locations. A wrong wrap would return bytes from beyond the top or would stall the stream. It feeds start addresses with nonzero upper bits, which a design using the full 24 bits would turn into wrong data. It checks that a complementary mode field, and only that field, lets the next cycle go without an instruction. A design that got this wrong would read the instruction bits as address and return bytes from the wrong place, or would miss a continuation. It issues reads while busy or without quad-enable, and sends foreign instructions. It also raises chip select in the middle of a byte. In each of these cases a faulty design would drive the data lines when it must not, or would keep them driven after deselection.

// File: rtl/dtr_rd_pkg.sv
// Shared definitions for the double-rate flash read responder.
package dtr_rd_pkg;

    // Phase of one chip-select cycle.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } phase_t;

    // Width of the address sent by the host.
    localparam int ADDR_BITS = 24;
    // Number of physical data lines.
    localparam int IO_W      = 4;

endpackage

// File: rtl/dtr_rd_edge.sv
// Pin sampler. Registers chip select, the serial clock and the data lines
// in the system-clock domain, then reports chip-select activity and the
// serial-clock edges.
// Assumes the pins are already synchronous to clk. The data lines are
// delayed one stage further than the clock, so the value reported with an
// edge is the one that was present just before that edge.
module dtr_rd_edge
    import dtr_rd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic [IO_W-1:0] sio_in,
    output logic            sel,
    output logic            sel_start,
    output logic            sck_rise,
    output logic            sck_fall,
    output logic [IO_W-1:0] sio_s
);

    logic            cs_q;
    logic            sel_d;
    logic            sclk_q;
    logic            sclk_qq;
    logic [IO_W-1:0] sio_q;
    logic [IO_W-1:0] sio_qq;

    // Sample the pins and keep one extra stage for edge and data alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            sel_d   <= 1'b0;
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            sio_q   <= '0;
            sio_qq  <= '0;
        end else begin
            cs_q    <= cs_n;
            sel_d   <= ~cs_q;
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            sio_q   <= sio_in;
            sio_qq  <= sio_q;
        end
    end

    // Edge and selection events, valid only while selected.
    always_comb begin
        sel       = ~cs_q;
        sel_start = sel & ~sel_d;
        sck_rise  = sel & sclk_q & ~sclk_qq;
        sck_fall  = sel & ~sclk_q & sclk_qq;
        sio_s     = sio_qq;
    end

endmodule

// File: rtl/dtr_rd_ctrl.sv
// Command sequencer. Captures the instruction, the address and the mode
// field, counts dummy clocks, and applies the busy and quad-enable gates.
// Also holds the continuation flag that lets the next cycle skip the
// instruction.
// Assumes the edge events come from dtr_rd_edge. The first address edge is
// a rising edge, and every address or mode phase ends on a falling edge.
module dtr_rd_ctrl
    import dtr_rd_pkg::*;
#(
    parameter logic [7:0] OPC_DUAL   = 8'hBD,
    parameter logic [7:0] OPC_QUAD   = 8'hED,
    parameter int         DUAL_DUMMY = 6,
    parameter int         QUAD_DUMMY = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 sel_start,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    input  logic [IO_W-1:0]      sio_s,
    input  logic                 busy,
    input  logic                 quad_en,
    output logic                 quad,
    output logic [ADDR_BITS-1:0] addr,
    output logic                 fetch_first,
    output logic                 data_start,
    output logic                 acc_dual,
    output logic                 acc_quad
);

    localparam int CNT_W = 5;
    localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(8);
    localparam logic [CNT_W-1:0] ADDR_LAST2 = CNT_W'(ADDR_BITS / 2 - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST4 = CNT_W'(ADDR_BITS / 4 - 1);
    localparam logic [CNT_W-1:0] DUM_LAST2  = CNT_W'(DUAL_DUMMY - 1);
    localparam logic [CNT_W-1:0] DUM_LAST4  = CNT_W'(QUAD_DUMMY - 1);

    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       opc;
    logic [3:0]       mode_hi;
    logic             armed;
    logic             any_edge;
    logic [CNT_W-1:0] addr_last;
    logic [CNT_W-1:0] dum_last;

    // Per-width phase limits and the both-edge strobe.
    always_comb begin
        any_edge  = sck_rise | sck_fall;
        addr_last = quad ? ADDR_LAST4 : ADDR_LAST2;
        dum_last  = quad ? DUM_LAST4 : DUM_LAST2;
    end

    // Phase sequencing, field capture and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph          <= PH_IDLE;
            cnt         <= '0;
            opc         <= '0;
            mode_hi     <= '0;
            armed       <= 1'b0;
            quad        <= 1'b0;
            addr        <= '0;
            fetch_first <= 1'b0;
            data_start  <= 1'b0;
            acc_dual    <= 1'b0;
            acc_quad    <= 1'b0;
        end else begin
            fetch_first <= 1'b0;
            data_start  <= 1'b0;
            acc_dual    <= 1'b0;
            acc_quad    <= 1'b0;
            if (!sel) begin
                ph <= PH_IDLE;
            end else begin
                case (ph)
                    PH_IDLE: begin
                        if (sel_start) begin
                            cnt  <= '0;
                            addr <= '0;
                            if (armed) begin
                                armed <= 1'b0;
                                if (busy || !quad_en) begin
                                    ph <= PH_SKIP;
                                end else begin
                                    ph       <= PH_ADDR;
                                    quad     <= 1'b1;
                                    acc_quad <= 1'b1;
                                end
                            end else begin
                                ph <= PH_OPC;
                            end
                        end
                    end
                    PH_OPC: begin
                        if (sck_rise) begin
                            opc <= {opc[6:0], sio_s[0]};
                            cnt <= cnt + 1'b1;
                        end else if (sck_fall && cnt == OPC_LAST) begin
                            cnt <= '0;
                            if (opc == OPC_DUAL && !busy) begin
                                ph       <= PH_ADDR;
                                quad     <= 1'b0;
                                acc_dual <= 1'b1;
                            end else if (opc == OPC_QUAD && !busy && quad_en) begin
                                ph       <= PH_ADDR;
                                quad     <= 1'b1;
                                acc_quad <= 1'b1;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end
                    end
                    PH_ADDR: begin
                        if (any_edge) begin
                            if (quad) begin
                                addr <= {addr[ADDR_BITS-5:0], sio_s};
                            end else begin
                                addr <= {addr[ADDR_BITS-3:0], sio_s[1:0]};
                            end
                            if (cnt == addr_last) begin
                                cnt         <= '0;
                                fetch_first <= 1'b1;
                                ph          <= quad ? PH_MODE : PH_DUMMY;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    PH_MODE: begin
                        if (sck_rise) begin
                            mode_hi <= sio_s;
                        end else if (sck_fall) begin
                            armed <= (mode_hi == ~sio_s);
                            ph    <= PH_DUMMY;
                        end
                    end
                    PH_DUMMY: begin
                        if (sck_fall) begin
                            if (cnt == dum_last) begin
                                cnt        <= '0;
                                data_start <= 1'b1;
                                ph         <= PH_DATA;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    PH_DATA: ph <= PH_DATA;
                    PH_SKIP: ph <= PH_SKIP;
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dtr_rd_serdes.sv
// Data streamer. Issues array reads with a one-byte prefetch, shifts the
// current byte out 2 or 4 bits per serial edge, and drives the output
// enables.
// Assumes a one-cycle read latency. Also assumes at least two serial edges
// per byte, each at least four system clocks apart, so every prefetch
// lands before it is needed.
module dtr_rd_serdes
    import dtr_rd_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            quad,
    input  logic            load,
    input  logic [AW-1:0]   load_addr,
    input  logic            start,
    input  logic            step,
    input  logic [7:0]      mem_rdata,
    output logic            mem_rd,
    output logic [AW-1:0]   mem_addr,
    output logic [IO_W-1:0] sio_out,
    output logic [IO_W-1:0] sio_oe
);

    logic [AW-1:0] faddr;
    logic          pend;
    logic [7:0]    nbuf;
    logic [7:0]    dbyte;
    logic [1:0]    slot;
    logic          run;
    logic [1:0]    last_slot;

    // Slots per byte minus one for the active line count.
    always_comb last_slot = quad ? 2'd1 : 2'd3;

    // Fetch, prefetch capture and byte shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            faddr    <= '0;
            pend     <= 1'b0;
            nbuf     <= '0;
            dbyte    <= '0;
            slot     <= '0;
            run      <= 1'b0;
            mem_rd   <= 1'b0;
            mem_addr <= '0;
        end else begin
            mem_rd <= 1'b0;
            pend   <= mem_rd;
            if (pend) begin
                nbuf <= mem_rdata;
            end
            if (!sel) begin
                run <= 1'b0;
            end else if (load) begin
                mem_rd   <= 1'b1;
                mem_addr <= load_addr;
                faddr    <= load_addr + 1'b1;
            end else if (start) begin
                run      <= 1'b1;
                dbyte    <= nbuf;
                slot     <= '0;
                mem_rd   <= 1'b1;
                mem_addr <= faddr;
                faddr    <= faddr + 1'b1;
            end else if (run && step) begin
                if (slot == last_slot) begin
                    dbyte    <= nbuf;
                    slot     <= '0;
                    mem_rd   <= 1'b1;
                    mem_addr <= faddr;
                    faddr    <= faddr + 1'b1;
                end else begin
                    dbyte <= quad ? {dbyte[3:0], 4'b0000} : {dbyte[5:0], 2'b00};
                    slot  <= slot + 1'b1;
                end
            end
        end
    end

    // Pin drive: top bits of the current byte, enabled only while streaming.
    always_comb begin
        if (!run) begin
            sio_out = '0;
            sio_oe  = '0;
        end else if (quad) begin
            sio_out = dbyte[7:4];
            sio_oe  = 4'b1111;
        end else begin
            sio_out = {2'b00, dbyte[7:6]};
            sio_oe  = 4'b0011;
        end
    end

endmodule

// File: rtl/dtr_flash_rd.sv
// Top of the double-rate flash read responder. Wires the pin sampler, the
// command sequencer and the data streamer together.
// Assumes ARRAY_AW is at most the 24-bit host address width. Address bits
// above the array are dropped here.
module dtr_flash_rd
    import dtr_rd_pkg::*;
#(
    parameter int         ARRAY_AW   = 24,
    parameter logic [7:0] OPC_DUAL   = 8'hBD,
    parameter logic [7:0] OPC_QUAD   = 8'hED,
    parameter int         DUAL_DUMMY = 6,
    parameter int         QUAD_DUMMY = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic [3:0]          sio_in,
    output logic [3:0]          sio_out,
    output logic [3:0]          sio_oe,
    input  logic                quad_en,
    input  logic                busy,
    output logic                mem_rd,
    output logic [ARRAY_AW-1:0] mem_addr,
    input  logic [7:0]          mem_rdata
);

    logic                 sel;
    logic                 sel_start;
    logic                 sck_rise;
    logic                 sck_fall;
    logic [IO_W-1:0]      sio_s;
    logic                 quad;
    logic [ADDR_BITS-1:0] host_addr;
    logic                 fetch_first;
    logic                 data_start;
    logic                 acc_dual;
    logic                 acc_quad;
    logic                 step;

    // Any serial edge advances the output stream.
    always_comb step = sck_rise | sck_fall;

    // Drop host address bits above the array.
    generate
        if (ARRAY_AW < ADDR_BITS) begin : g_trim
            logic unused_hi;
            assign unused_hi = ^host_addr[ADDR_BITS-1:ARRAY_AW];
        end
    endgenerate

    dtr_rd_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sio_in    (sio_in),
        .sel       (sel),
        .sel_start (sel_start),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sio_s     (sio_s)
    );

    dtr_rd_ctrl #(
        .OPC_DUAL   (OPC_DUAL),
        .OPC_QUAD   (OPC_QUAD),
        .DUAL_DUMMY (DUAL_DUMMY),
        .QUAD_DUMMY (QUAD_DUMMY)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .sel_start   (sel_start),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .sio_s       (sio_s),
        .busy        (busy),
        .quad_en     (quad_en),
        .quad        (quad),
        .addr        (host_addr),
        .fetch_first (fetch_first),
        .data_start  (data_start),
        .acc_dual    (acc_dual),
        .acc_quad    (acc_quad)
    );

    dtr_rd_serdes #(
        .AW (ARRAY_AW)
    ) u_serdes (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .quad      (quad),
        .load      (fetch_first),
        .load_addr (host_addr[ARRAY_AW-1:0]),
        .start     (data_start),
        .step      (step),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .sio_out   (sio_out),
        .sio_oe    (sio_oe)
    );

endmodule

// File: rtl/dtr_flash_rd_chk.sv
// Property checker for dtr_flash_rd, attached to it with a bind statement.
// Relates the pin-side selection, the gate pulses and the array port over
// time.
module dtr_flash_rd_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          busy,
    input logic          quad_en,
    input logic          acc_dual,
    input logic          acc_quad,
    input logic          fetch_first,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    sio_oe
);

    logic [AW-1:0] last_a;

    // Remember the address of the most recent array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_a <= '0;
        end else if (mem_rd) begin
            last_a <= mem_addr;
        end
    end

    assert_oe_off_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> sio_oe == 4'b0000);

    assert_rd_quiet_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !mem_rd);

    assert_oe_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe == 4'b0000 || sio_oe == 4'b0011 || sio_oe == 4'b1111);

    assert_quad_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_quad |-> $past(quad_en));

    assert_busy_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_dual || acc_quad) |-> !$past(busy));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !$past(fetch_first)) |-> mem_addr == last_a + 1'b1);

endmodule

bind dtr_flash_rd dtr_flash_rd_chk #(.AW(ARRAY_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .busy        (busy),
    .quad_en     (quad_en),
    .acc_dual    (acc_dual),
    .acc_quad    (acc_quad),
    .fetch_first (fetch_first),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .sio_oe      (sio_oe)
);

// File: tb/dtr_flash_rd_bench.sv
`timescale 1ns/1ps
module dtr_flash_rd_bench;

    localparam int         AW    = 8;
    localparam int         HALF  = 4;
    localparam logic [7:0] OP_D  = 8'hBD;
    localparam logic [7:0] OP_Q  = 8'hED;
    localparam int         WD    = 150000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n;
    logic          sclk;
    logic [3:0]    sio_in;
    logic [3:0]    sio_out;
    logic [3:0]    sio_oe;
    logic          quad_en;
    logic          busy;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;
    bit mon_en = 0;
    bit mon_hit = 0;
    logic [7:0] mem [1 << AW];

    always #2.5 clk = ~clk;

    dtr_flash_rd #(.ARRAY_AW(AW)) u_dtr_flash_rd (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sio_in(sio_in),
        .sio_out(sio_out), .sio_oe(sio_oe), .quad_en(quad_en), .busy(busy),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    // Array model with one-cycle read latency.
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    // Watches for any driven line while mon_en is set.
    always @(posedge clk) if (mon_en && sio_oe != 4'b0000) mon_hit = 1'b1;

    function automatic logic [7:0] pat(input logic [7:0] a);
        logic [7:0] m;
        m = a * 8'd29;
        return m ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_op(input logic [7:0] op);
        for (int i = 7; i >= 0; i--) begin
            sio_in = {3'b000, op[i]};
            wait_h(); sclk = 1'b1;
            wait_h(); sclk = 1'b0;
        end
    endtask

    task automatic send_addr(input bit quad, input logic [23:0] a);
        logic [23:0] sh;
        sh = a;
        for (int e = 0; e < (quad ? 6 : 12); e++) begin
            if (quad) begin
                sio_in = sh[23:20]; sh = sh << 4;
            end else begin
                sio_in = {2'b00, sh[23:22]}; sh = sh << 2;
            end
            wait_h(); sclk = ~sclk;
        end
    endtask

    task automatic send_mode(input logic [7:0] p);
        sio_in = p[7:4]; wait_h(); sclk = 1'b1;
        sio_in = p[3:0]; wait_h(); sclk = 1'b0;
    endtask

    task automatic dummy(input int n);
        sio_in = 4'b0000;
        for (int i = 0; i < n; i++) begin
            wait_h(); sclk = 1'b1;
            wait_h(); sclk = 1'b0;
        end
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0; sio_in = 4'b0000;
        repeat (6) @(negedge clk);
    endtask

    // One full read; checks every byte and the enables before data.
    task automatic do_read(input bit quad, input bit with_opc, input logic [23:0] a,
                           input logic [7:0] pm, input int nb, input string req);
        logic [7:0] got;
        logic [3:0] oe_exp;
        bit oe_bad;
        mon_hit = 1'b0; mon_en = 1'b1;
        cs_n = 1'b0; wait_h();
        if (with_opc) send_op(quad ? OP_Q : OP_D);
        send_addr(quad, a);
        if (quad) send_mode(pm);
        dummy(quad ? 7 : 6);
        mon_en = 1'b0;
        check(!mon_hit, "R10", "lines driven before data", 32'(mon_hit), 0);
        oe_exp = quad ? 4'b1111 : 4'b0011;
        for (int b = 0; b < nb; b++) begin
            got = '0; oe_bad = 1'b0;
            for (int s = 0; s < (quad ? 2 : 4); s++) begin
                if (!(b == 0 && s == 0)) sclk = ~sclk;
                wait_h();
                got = quad ? {got[3:0], sio_out} : {got[5:0], sio_out[1:0]};
                if (sio_oe != oe_exp) oe_bad = 1'b1;
            end
            check(got == pat(8'(a[7:0] + b)), req, "data byte", got, pat(8'(a[7:0] + b)));
            check(!oe_bad, "R10", "data enables", 32'(oe_bad), 0);
        end
        deselect();
    endtask

    // A cycle that must never drive the lines.
    task automatic do_reject(input logic [7:0] op, input bit quad, input string req);
        mon_hit = 1'b0; mon_en = 1'b1;
        cs_n = 1'b0; wait_h();
        send_op(op);
        send_addr(quad, 24'h000040);
        if (quad) send_mode(8'h00);
        dummy(quad ? 7 : 6);
        for (int i = 0; i < 8; i++) begin
            wait_h(); sclk = ~sclk;
        end
        wait_h();
        mon_en = 1'b0;
        check(!mon_hit, req, "rejected read drove lines", 32'(mon_hit), 0);
        deselect();
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << AW); i++) mem[i] = pat(8'(i));
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sio_in = 4'b0000;
        quad_en = 1'b1; busy = 1'b0;
        repeat (3) @(negedge clk);
        check(sio_oe == 4'b0000 && !mem_rd, "R11", "in reset", {sio_oe, 3'b0, mem_rd}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sio_oe == 4'b0000 && !mem_rd, "R11", "after reset", {sio_oe, 3'b0, mem_rd}, 0);

        // Basic two-line and four-line reads (R2, R3, R4).
        do_read(1'b0, 1'b1, 24'h000010, 8'h00, 4, "R2");
        do_read(1'b1, 1'b1, 24'h0000A3, 8'h00, 4, "R3");
        // Wrap at the top and upper address bits ignored (R5).
        do_read(1'b1, 1'b1, 24'h0000FE, 8'h11, 4, "R5");
        do_read(1'b0, 1'b1, 24'h1234FF, 8'h00, 3, "R5");

        // Gates (R6, R7) and foreign instruction (R1).
        quad_en = 1'b0;
        do_reject(OP_Q, 1'b1, "R6");
        do_read(1'b0, 1'b1, 24'h000020, 8'h00, 2, "R6");
        quad_en = 1'b1;
        busy = 1'b1;
        do_reject(OP_D, 1'b0, "R7");
        do_reject(OP_Q, 1'b1, "R7");
        busy = 1'b0;
        do_reject(8'h3B, 1'b0, "R1");
        do_read(1'b1, 1'b1, 24'h000033, 8'h00, 2, "R1");

        // Continuation (R8).
        do_read(1'b1, 1'b1, 24'h000050, 8'hA5, 2, "R8");
        do_read(1'b1, 1'b0, 24'h0000C7, 8'h00, 3, "R8");
        do_read(1'b0, 1'b1, 24'h000061, 8'h00, 2, "R8");
        do_read(1'b1, 1'b1, 24'h000070, 8'hAA, 1, "R8");
        do_read(1'b1, 1'b1, 24'h000071, 8'h00, 2, "R8");

        // Abort mid-byte (R9).
        cs_n = 1'b0; wait_h();
        send_op(OP_D); send_addr(1'b0, 24'h000090); dummy(6);
        wait_h(); sclk = ~sclk; wait_h();
        check(sio_oe == 4'b0011, "R9", "enables before abort", sio_oe, 4'b0011);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sio_oe == 4'b0000, "R9", "enables after abort", sio_oe, 0);
        deselect();
        do_read(1'b0, 1'b1, 24'h000091, 8'h00, 2, "R9");

        // Random reads.
        for (int k = 0; k < 20; k++) begin
            bit q;
            logic [23:0] a;
            logic [3:0] r;
            q = 1'($urandom());
            a = 24'($urandom());
            r = 4'($urandom());
            do_read(q, 1'b1, a, {r, r}, 1 + int'($urandom() % 5), q ? "R3" : "R2");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule